// File: doc/BRIEF.md
# UART Loop-Back Diagnostic Router

This block sits between one UART channel's external pins and its internal serializer, deserializer and modem-status logic. In normal operation it passes the transmit and receive serial streams straight through. It drives the four modem output pins from the modem control bits, and it presents the four modem input pins to the status logic. When the loop-back control bit is set, the block isolates the channel from the board. The serializer output is returned to the deserializer, the TX pin is parked at mark, and the modem output pins go inactive. Each modem input is then fed from one of the modem control bits, so software can test the whole channel without external wiring.

The block also keeps the modem status register. Its upper nibble shows the synchronized state of the four modem inputs, taken from whichever source is active. Its lower nibble holds sticky change flags. The flags are cleared by a status read and raise an interrupt request when the interrupt is enabled. Because the flags watch the selected source, entering or leaving loop-back can set them.

Top module: `uart_loopback_router`

## Requirements
- R1: With loop-back off (control bit 4 = 0), `txPin` follows `txSerial` and `rxSerial` follows `rxPin`. The active-low outputs `dtrPinN`, `rtsPinN`, `op1PinN` and `op2PinN` are the inverses of control bits 0, 1, 2 and 3 respectively.
- R2: With loop-back on, `rxSerial` follows `txSerial`, `txPin` is held at 1, and `rxPin` has no effect.
- R3: With loop-back on, all four modem output pins are held at 1 (inactive), whatever control bits 0 to 3 hold.
- R4: With loop-back on, the internal CTS is taken from control bit 1, DSR from bit 0, RI from bit 2 and CD from bit 3. The modem input pins have no effect.
- R5: `msrValue` bits 4, 5, 6 and 7 show the active-high states of CTS, DSR, RI and CD. In normal mode these are the inverted pin levels. A source change reaches them after `SYNC_STAGES` clock edges, and reset clears them to 0.
- R6: `msrValue` bits 0, 1 and 3 are set one edge after the CTS, DSR or CD state bit (respectively) changes in either direction. They stay set until cleared.
- R7: `msrValue` bit 2 is set only when the RI state bit goes from 1 to 0. A 0-to-1 change does not set it.
- R8: `msrRead` high at a clock edge clears all four change bits. A change detected at that same edge still sets its bit.
- R9: `modemIrq` is high exactly when `msrIntEn` is high and at least one change bit is set.
- R10: After reset, `msrValue` is 0 and `modemIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mcrBits | input | 5 | Modem control: bit0 DTR, bit1 RTS, bit2 OP1, bit3 OP2, bit4 loop-back enable |
| msrRead | input | 1 | Status register read strobe |
| msrIntEn | input | 1 | Modem-status interrupt enable |
| txSerial | input | 1 | Serial data from the serializer |
| rxPin | input | 1 | RX pin |
| ctsPinN | input | 1 | CTS pin, active low |
| dsrPinN | input | 1 | DSR pin, active low |
| dcdPinN | input | 1 | CD pin, active low |
| riPinN | input | 1 | RI pin, active low |
| txPin | output | 1 | TX pin |
| rxSerial | output | 1 | Serial data to the deserializer |
| rtsPinN | output | 1 | RTS pin, active low |
| dtrPinN | output | 1 | DTR pin, active low |
| op1PinN | output | 1 | OP1 pin, active low |
| op2PinN | output | 1 | OP2 pin, active low |
| msrValue | output | 8 | Modem status register |
| modemIrq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. This checks that the state latency and the change-flag timing follow the parameter instead of a fixed two-edge delay. At that depth, noise toggled on the pins while in loop-back stays invisible, and mode switches ripple through a longer pipeline. Reads that coincide with a fresh change are also easier to hit, which exercises the priority of a new change over a clear.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int MCR_W     = 5;
  localparam int MODEM_W   = 4;
  localparam int MCR_DTR   = 0;
  localparam int MCR_RTS   = 1;
  localparam int MCR_OP1   = 2;
  localparam int MCR_OP2   = 3;
  localparam int MCR_LOOP  = 4;
  // modem state vector order, matches status bits 4..7
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_CD  = 3;

  typedef struct packed {
    logic loopOn;
    logic clearDelta;
  } lbStrobes_t;
endpackage

// File: rtl/ulb_ctrl.sv
module ulb_ctrl
  import uart_lb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MCR_W-1:0] mcrBits,
  input  logic             msrRead,
  output lbStrobes_t       strb,
  output logic             rtsPinN,
  output logic             dtrPinN,
  output logic             op1PinN,
  output logic             op2PinN
);
  always_comb begin
    strb.loopOn     = mcrBits[MCR_LOOP];
    strb.clearDelta = msrRead;
  end

  // pins are isolated (inactive high) while looped back
  always_comb begin
    rtsPinN = strb.loopOn | ~mcrBits[MCR_RTS];
    dtrPinN = strb.loopOn | ~mcrBits[MCR_DTR];
    op1PinN = strb.loopOn | ~mcrBits[MCR_OP1];
    op2PinN = strb.loopOn | ~mcrBits[MCR_OP2];
  end

  p_pins_inactive_r3: assert property (@(posedge clk) disable iff (!rstN)
    mcrBits[MCR_LOOP] |-> (rtsPinN && dtrPinN && op1PinN && op2PinN));
endmodule

// File: rtl/ulb_datapath.sv
module ulb_datapath
  import uart_lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  lbStrobes_t         strb,
  input  logic [MODEM_W-1:0] mcrModem,
  input  logic               msrIntEn,
  input  logic               txSerial,
  input  logic               rxPin,
  input  logic               ctsPinN,
  input  logic               dsrPinN,
  input  logic               dcdPinN,
  input  logic               riPinN,
  output logic               txPin,
  output logic               rxSerial,
  output logic [7:0]         msrValue,
  output logic               modemIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [MODEM_W-1:0] srcVec, stateNow, prevQ, deltaQ, eventVec;
  logic [MODEM_W-1:0] syncQ [SYNC_STAGES];

  // serial path
  always_comb begin
    txPin    = strb.loopOn ? 1'b1 : txSerial;
    rxSerial = strb.loopOn ? txSerial : rxPin;
  end

  // modem input source: crossover in loop-back, inverted pins otherwise
  always_comb begin
    if (strb.loopOn) begin
      srcVec[ST_CTS] = mcrModem[MCR_RTS];
      srcVec[ST_DSR] = mcrModem[MCR_DTR];
      srcVec[ST_RI]  = mcrModem[MCR_OP1];
      srcVec[ST_CD]  = mcrModem[MCR_OP2];
    end else begin
      srcVec[ST_CTS] = ~ctsPinN;
      srcVec[ST_DSR] = ~dsrPinN;
      srcVec[ST_RI]  = ~riPinN;
      srcVec[ST_CD]  = ~dcdPinN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= srcVec;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= '0;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign stateNow = syncQ[LAST];

  always_comb begin
    eventVec         = stateNow ^ prevQ;
    eventVec[ST_RI]  = prevQ[ST_RI] & ~stateNow[ST_RI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      deltaQ <= '0;
    end else begin
      prevQ  <= stateNow;
      deltaQ <= (deltaQ & ~{MODEM_W{strb.clearDelta}}) | eventVec;
    end
  end

  always_comb begin
    msrValue = {stateNow, deltaQ};
    modemIrq = msrIntEn & (|deltaQ);
  end

  p_loop_route_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loopOn |-> (rxSerial == txSerial) && txPin);
  p_ri_trailing_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deltaQ[ST_RI]) |-> $past(prevQ[ST_RI]) && !$past(stateNow[ST_RI]));
  p_delta_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (deltaQ[ST_CTS] && !strb.clearDelta) |=> deltaQ[ST_CTS]);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearDelta && (eventVec == '0)) |=> (deltaQ == '0));
  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modemIrq) |-> msrIntEn);
endmodule

// File: rtl/uart_loopback_router.sv
module uart_loopback_router
  import uart_lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MCR_W-1:0] mcrBits,
  input  logic             msrRead,
  input  logic             msrIntEn,
  input  logic             txSerial,
  input  logic             rxPin,
  input  logic             ctsPinN,
  input  logic             dsrPinN,
  input  logic             dcdPinN,
  input  logic             riPinN,
  output logic             txPin,
  output logic             rxSerial,
  output logic             rtsPinN,
  output logic             dtrPinN,
  output logic             op1PinN,
  output logic             op2PinN,
  output logic [7:0]       msrValue,
  output logic             modemIrq
);
  lbStrobes_t strb;

  ulb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mcrBits(mcrBits), .msrRead(msrRead), .strb(strb),
    .rtsPinN(rtsPinN), .dtrPinN(dtrPinN), .op1PinN(op1PinN), .op2PinN(op2PinN)
  );

  ulb_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mcrModem(mcrBits[MODEM_W-1:0]),
    .msrIntEn(msrIntEn), .txSerial(txSerial), .rxPin(rxPin),
    .ctsPinN(ctsPinN), .dsrPinN(dsrPinN), .dcdPinN(dcdPinN), .riPinN(riPinN),
    .txPin(txPin), .rxSerial(rxSerial), .msrValue(msrValue), .modemIrq(modemIrq)
  );
endmodule

// File: tb/uart_loopback_router_tb.sv
module uart_loopback_router_tb;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] mcrBits = '0;
  logic msrRead = 0, msrIntEn = 0, txSerial = 1, rxPin = 1;
  logic ctsPinN = 1, dsrPinN = 1, dcdPinN = 1, riPinN = 1;
  logic txPin, rxSerial, rtsPinN, dtrPinN, op1PinN, op2PinN, modemIrq;
  logic [7:0] msrValue;

  int compared = 0, mismatched = 0;
  bit running = 1'b1;

  always #5 clk = ~clk;

  uart_loopback_router #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .mcrBits(mcrBits), .msrRead(msrRead), .msrIntEn(msrIntEn),
    .txSerial(txSerial), .rxPin(rxPin), .ctsPinN(ctsPinN), .dsrPinN(dsrPinN),
    .dcdPinN(dcdPinN), .riPinN(riPinN), .txPin(txPin), .rxSerial(rxSerial),
    .rtsPinN(rtsPinN), .dtrPinN(dtrPinN), .op1PinN(op1PinN), .op2PinN(op2PinN),
    .msrValue(msrValue), .modemIrq(modemIrq)
  );

  // reference model: history of sampled sources, index 0 = newest
  logic [3:0] hist[$];
  logic [3:0] mDelta;

  function automatic logic [3:0] srcNow();
    // order {cd, ri, dsr, cts}
    if (mcrBits[4]) return {mcrBits[3], mcrBits[2], mcrBits[0], mcrBits[1]};
    return ~{dcdPinN, riPinN, dsrPinN, ctsPinN};
  endfunction

  task automatic resetModel();
    hist.delete();
    for (int i = 0; i < SYNC + 2; i++) hist.push_front(4'b0);
    mDelta = '0;
  endtask

  initial resetModel();

  always @(posedge clk) begin
    if (!rstN) resetModel();
    else begin
      logic [3:0] ev;
      hist.push_front(srcNow());
      ev = hist[SYNC] ^ hist[SYNC+1];
      ev[2] = hist[SYNC+1][2] & ~hist[SYNC][2];
      mDelta = (mDelta & ~{4{msrRead}}) | ev;
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    logic lp;
    lp = mcrBits[4];
    if (lp) begin
      check("R2 txPin", {7'b0, txPin}, 8'h01);
      check("R2 rxSerial", {7'b0, rxSerial}, {7'b0, txSerial});
      check("R3 pins", {4'b0, rtsPinN, dtrPinN, op1PinN, op2PinN}, 8'h0F);
      check("R4 R5 state", {4'b0, msrValue[7:4]}, {4'b0, hist[SYNC-1]});
    end else begin
      check("R1 txPin", {7'b0, txPin}, {7'b0, txSerial});
      check("R1 rxSerial", {7'b0, rxSerial}, {7'b0, rxPin});
      check("R1 pins", {4'b0, rtsPinN, dtrPinN, op1PinN, op2PinN},
            {4'b0, ~mcrBits[1], ~mcrBits[0], ~mcrBits[2], ~mcrBits[3]});
      check("R5 state", {4'b0, msrValue[7:4]}, {4'b0, hist[SYNC-1]});
    end
    check("R6 R8 delta", {5'b0, msrValue[3], msrValue[1:0]},
          {5'b0, mDelta[3], mDelta[1:0]});
    check("R7 R8 ri delta", {7'b0, msrValue[2]}, {7'b0, mDelta[2]});
    check("R9 irq", {7'b0, modemIrq}, {7'b0, msrIntEn & (|mDelta)});
  endtask

  task automatic stepRandom(bit loop, int readPct, int pinFlipPct);
    @(negedge clk);
    compareAll();
    mcrBits[4] = loop;
    if ($urandom_range(99) < 30) mcrBits[3:0] = 4'($urandom());
    txSerial = 1'($urandom());
    rxPin    = 1'($urandom());
    if ($urandom_range(99) < pinFlipPct) ctsPinN = ~ctsPinN;
    if ($urandom_range(99) < pinFlipPct) dsrPinN = ~dsrPinN;
    if ($urandom_range(99) < pinFlipPct) dcdPinN = ~dcdPinN;
    if ($urandom_range(99) < pinFlipPct) riPinN  = ~riPinN;
    msrRead  = ($urandom_range(99) < readPct);
    msrIntEn = ($urandom_range(99) < 80);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      msrRead = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 msr", msrValue, 8'h00);
    check("R10 irq", {7'b0, modemIrq}, 8'h00);
    // R7 directed: RI activation must not set bit 2, release must
    riPinN = 0; idle(SYNC + 3);
    check("R7 no rise flag", {7'b0, msrValue[2]}, 8'h00);
    riPinN = 1; idle(SYNC + 3);
    check("R7 fall flag", {7'b0, msrValue[2]}, 8'h01);
    msrRead = 1; idle(2);
    check("R8 cleared", {4'b0, msrValue[3:0]}, 8'h00);
    // normal mode random traffic
    for (int i = 0; i < 800; i++) stepRandom(1'b0, 15, 20);
    // loop-back, pins toggling as noise (R4)
    for (int i = 0; i < 800; i++) stepRandom(1'b1, 15, 50);
    // frequent mode switching
    for (int i = 0; i < 600; i++) stepRandom(($urandom_range(9) < 3) ? ~mcrBits[4] : mcrBits[4], 25, 20);
    // heavy reads, coinciding with changes (R8)
    for (int i = 0; i < 400; i++) stepRandom(mcrBits[4], 70, 40);
    idle(SYNC + 3);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (running) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule